// File: doc/BRIEF.md
# Hashed Page Table Group Walker

This block locates and scans one group of a hashed page table for a demand-paged virtual memory system. A requester presents a segment identifier, a 16-bit page index, the table base, a table size mask and a primary/secondary choice, then pulses `start`. The block hashes the request into a 64-byte-aligned group address inside a power-of-two table whose base is a multiple of its size. It then puts out one 8-byte entry address per cycle and compares the entry that comes back in the same cycle against the request.

The walk stops at the first entry that matches. If none of the eight entries matches, the walk ends with a miss, and the requester may retry with the secondary hash or raise a fault. The result stays on the outputs until the next accepted search.

Top module: `ptw_grp_walker`

## Requirements
- R1: After reset, `busy`, `done`, `hit` and `ent_rd` are 0, and `hit_idx` and `hit_ppn` are 0.
- R2: The primary hash is the XOR of `vsid[18:0]` with the page index zero-extended to 19 bits. The first entry address of a search is the group address, formed as {`tbl_base[31:25]`, `tbl_base[24:16]` OR (hash[18:10] AND `tbl_mask`), hash[9:0], 6'b0}.
- R3: When `sec`=1, the ones' complement of the primary hash is used in place of the primary hash.
- R4: The mask gates only hash bits 18:10. Base bits 31:25 pass straight through. Base bits 15:0 take no part in the address.
- R5: Once a search is accepted, the next cycle begins a run of `ent_rd`=1 cycles. In run cycle i, `ent_addr` = group address + 8*i, for i = 0 up to the stop index. The low 6 bits of the group address are always 0.
- R6: An entry word `ent_data` matches when all four of these hold: bit 63 (valid) = 1, bits 62:39 equal `vsid`, bit 38 equals `sec`, and bits 37:32 equal `pidx[15:10]`. The walk stops at the first matching index k. It then reports `hit`=1, `hit_idx`=k and `hit_ppn`=`ent_data[31:12]` of that entry. Matching entries that come after k are never read.
- R7: If none of the eight entries matches, exactly eight reads take place, followed by `done` with `hit`=0, `hit_idx`=0 and `hit_ppn`=0.
- R8: `done` is 1 for exactly one cycle, in the cycle after the last read, and `ent_rd` is 0 in that cycle.
- R9: A `start` that arrives while `busy`=1 has no effect. The address sequence and the result of the search in progress are unchanged.
- R10: `hit`, `hit_idx` and `hit_ppn` change only at the edge that raises `done`, and they hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Search request pulse, taken only when idle |
| vsid | input | 24 | Virtual segment identifier |
| pidx | input | 16 | Page index (effective address bits above the 4 KB offset) |
| sec | input | 1 | 0 = primary hash, 1 = secondary hash |
| tbl_base | input | 32 | Table base address, a multiple of the table size |
| tbl_mask | input | 9 | Table size mask over hash bits 18:10 |
| busy | output | 1 | Walk in progress |
| ent_rd | output | 1 | Entry address valid this cycle |
| ent_addr | output | 32 | Byte address of the current entry |
| ent_data | input | 64 | Entry word for `ent_addr`, returned in the same cycle |
| done | output | 1 | One-cycle end-of-search pulse |
| hit | output | 1 | Last search found a match |
| hit_idx | output | 3 | Index of the matching entry |
| hit_ppn | output | 20 | Physical page number of the matching entry |

## Verification
The hardest cases to reach from the ports are the near-misses. These are entries that agree with the request in every field but one: the valid bit, one segment bit at either end of the identifier, the hash-select bit, or the abbreviated page index. A walk has to pass over such entries before it reaches the real match. The bench serves a table, built in the bench, that is placed only at the expected group address. It sweeps the position of the real match over all eight slots and the no-match case, under both hashes and several masks and bases, and puts a second matching entry after the first to show that the walk stops early. A stray `start` is injected partway through a walk to confirm that it is ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int P_VSID_W    = 24;
  localparam int P_PIDX_W    = 16;
  localparam int P_HASH_W    = 19;
  localparam int P_PA_W      = 32;
  localparam int P_PAGE_LG   = 12;
  localparam int P_MINTBL_LG = 16;
  localparam int P_N_ENT     = 8;
  localparam int P_ENT_LG    = 3;
  localparam int P_ENT_W     = 64;
  localparam int P_API_W     = 6;

  typedef enum logic [0:0] {
    W_IDLE = 1'b0,
    W_SCAN = 1'b1
  } walk_state_t;
endpackage

// File: rtl/ptw_hash.sv
module ptw_hash #(
  parameter int VSID_W    = ptw_pkg::P_VSID_W,
  parameter int PIDX_W    = ptw_pkg::P_PIDX_W,
  parameter int HASH_W    = ptw_pkg::P_HASH_W,
  parameter int PA_W      = ptw_pkg::P_PA_W,
  parameter int MINTBL_LG = ptw_pkg::P_MINTBL_LG,
  parameter int GRP_LG    = 6,
  localparam int LOW_W    = MINTBL_LG - GRP_LG,
  localparam int MSK_W    = HASH_W - LOW_W,
  localparam int TOP_W    = PA_W - MINTBL_LG - MSK_W
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] pidx,
  input  logic              sec,
  input  logic [PA_W-1:0]   base,
  input  logic [MSK_W-1:0]  mask,
  output logic [PA_W-1:0]   grp_addr
);
  function automatic logic [HASH_W-1:0] f_hash(input logic [VSID_W-1:0] v,
                                               input logic [PIDX_W-1:0] p,
                                               input logic s);
    logic [HASH_W-1:0] h;
    h = v[HASH_W-1:0] ^ HASH_W'(p);
    return s ? ~h : h;
  endfunction

  function automatic logic [PA_W-1:0] f_place(input logic [HASH_W-1:0] h,
                                              input logic [PA_W-1:0]   b,
                                              input logic [MSK_W-1:0]  m);
    logic [MSK_W-1:0] mid;
    mid = b[MINTBL_LG +: MSK_W] | (h[HASH_W-1:LOW_W] & m);
    return {b[PA_W-1 -: TOP_W], mid, h[LOW_W-1:0], {GRP_LG{1'b0}}};
  endfunction

  logic [HASH_W-1:0] hash_val;

  always_comb begin
    hash_val = f_hash(vsid, pidx, sec);
    grp_addr = f_place(hash_val, base, mask);
  end
endmodule

// File: rtl/ptw_match.sv
module ptw_match #(
  parameter int VSID_W = ptw_pkg::P_VSID_W,
  parameter int API_W  = ptw_pkg::P_API_W,
  parameter int PPN_W  = 20,
  parameter int ENT_W  = ptw_pkg::P_ENT_W,
  localparam int V_POS  = ENT_W - 1,
  localparam int VS_HI  = V_POS - 1,
  localparam int VS_LO  = VS_HI - VSID_W + 1,
  localparam int H_POS  = VS_LO - 1,
  localparam int API_HI = H_POS - 1,
  localparam int API_LO = API_HI - API_W + 1,
  localparam int PPN_HI = API_LO - 1,
  localparam int PPN_LO = PPN_HI - PPN_W + 1
) (
  input  logic [ENT_W-1:0]  ent,
  input  logic [VSID_W-1:0] want_vsid,
  input  logic [API_W-1:0]  want_api,
  input  logic              want_sec,
  output logic              is_match,
  output logic [PPN_W-1:0]  ppn
);
  logic f_valid, f_vsid, f_sec, f_api;

  always_comb begin
    f_valid  = ent[V_POS];
    f_vsid   = (ent[VS_HI:VS_LO] == want_vsid);
    f_sec    = (ent[H_POS] == want_sec);
    f_api    = (ent[API_HI:API_LO] == want_api);
    is_match = f_valid & f_vsid & f_sec & f_api;
    ppn      = ent[PPN_HI:PPN_LO];
  end
endmodule

// File: rtl/ptw_walk.sv
module ptw_walk #(
  parameter int N_ENT = ptw_pkg::P_N_ENT,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hit_now,
  output logic             busy,
  output logic             accept,
  output logic             finish,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  import ptw_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  walk_state_t state;
  logic        at_last;

  always_comb begin
    busy    = (state == W_SCAN);
    accept  = start && (state == W_IDLE);
    at_last = (idx == LAST);
    finish  = busy && (hit_now || at_last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= W_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        state <= W_SCAN;
        idx   <= '0;
      end else if (finish) begin
        state <= W_IDLE;
        idx   <= '0;
      end else if (busy) begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a running walk keeps stepping; start cannot restart it
  a_r9_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (idx == $past(idx) + 1'b1));

  // R8: done follows the end of a walk, and only then
  a_r8_done_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
endmodule

// File: rtl/ptw_grp_walker.sv
module ptw_grp_walker #(
  parameter int VSID_W    = ptw_pkg::P_VSID_W,
  parameter int PIDX_W    = ptw_pkg::P_PIDX_W,
  parameter int HASH_W    = ptw_pkg::P_HASH_W,
  parameter int PA_W      = ptw_pkg::P_PA_W,
  parameter int PAGE_LG   = ptw_pkg::P_PAGE_LG,
  parameter int MINTBL_LG = ptw_pkg::P_MINTBL_LG,
  parameter int N_ENT     = ptw_pkg::P_N_ENT,
  parameter int ENT_LG    = ptw_pkg::P_ENT_LG,
  parameter int ENT_W     = ptw_pkg::P_ENT_W,
  parameter int API_W     = ptw_pkg::P_API_W,
  localparam int IDX_W    = $clog2(N_ENT),
  localparam int GRP_LG   = IDX_W + ENT_LG,
  localparam int MSK_W    = HASH_W - (MINTBL_LG - GRP_LG),
  localparam int PPN_W    = PA_W - PAGE_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] pidx,
  input  logic              sec,
  input  logic [PA_W-1:0]   tbl_base,
  input  logic [MSK_W-1:0]  tbl_mask,
  output logic              busy,
  output logic              ent_rd,
  output logic [PA_W-1:0]   ent_addr,
  input  logic [ENT_W-1:0]  ent_data,
  output logic              done,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [PPN_W-1:0]  hit_ppn
);
  logic [PA_W-1:0]   grp_next;
  logic [PA_W-1:0]   grp_q;
  logic [VSID_W-1:0] vsid_q;
  logic [API_W-1:0]  api_q;
  logic              sec_q;
  logic              accept, finish, hit_now;
  logic [IDX_W-1:0]  idx;
  logic [PPN_W-1:0]  ppn_now;

  ptw_hash #(
    .VSID_W(VSID_W), .PIDX_W(PIDX_W), .HASH_W(HASH_W), .PA_W(PA_W),
    .MINTBL_LG(MINTBL_LG), .GRP_LG(GRP_LG)
  ) u_hash (
    .vsid(vsid), .pidx(pidx), .sec(sec), .base(tbl_base),
    .mask(tbl_mask), .grp_addr(grp_next)
  );

  ptw_match #(
    .VSID_W(VSID_W), .API_W(API_W), .PPN_W(PPN_W), .ENT_W(ENT_W)
  ) u_match (
    .ent(ent_data), .want_vsid(vsid_q), .want_api(api_q), .want_sec(sec_q),
    .is_match(hit_now), .ppn(ppn_now)
  );

  ptw_walk #(.N_ENT(N_ENT)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .hit_now(hit_now && busy),
    .busy(busy), .accept(accept), .finish(finish), .idx(idx), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q  <= '0;
      vsid_q <= '0;
      api_q  <= '0;
      sec_q  <= 1'b0;
    end else if (accept) begin
      grp_q  <= grp_next;
      vsid_q <= vsid;
      api_q  <= pidx[PIDX_W-1 -: API_W];
      sec_q  <= sec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit     <= 1'b0;
      hit_idx <= '0;
      hit_ppn <= '0;
    end else if (finish) begin
      hit     <= hit_now;
      hit_idx <= hit_now ? idx : '0;
      hit_ppn <= hit_now ? ppn_now : '0;
    end
  end

  always_comb begin
    ent_rd   = busy;
    ent_addr = {grp_q[PA_W-1:GRP_LG], idx, {ENT_LG{1'b0}}};
  end

  // R5: consecutive reads advance by one entry
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_rd && $past(ent_rd)) |-> (ent_addr == $past(ent_addr) + PA_W'(1 << ENT_LG)));

  // R5: the first read of a walk lands on a group boundary
  a_r5_first_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_rd && !$past(ent_rd)) |-> (ent_addr[GRP_LG-1:0] == '0));

  // R6: the reported index is the slot read in the final cycle
  a_r6_idx_last_read: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (hit_idx == $past(ent_addr[GRP_LG-1:ENT_LG])));

  // R7: a miss ends only after the last slot
  a_r7_miss_full: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> ($past(ent_addr[GRP_LG-1:ENT_LG]) == IDX_W'(N_ENT - 1)));

  // R10: results move only with done
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hit) && $stable(hit_idx) && $stable(hit_ppn)));
endmodule

// File: tb/test_ptw_grp_walker.sv
module test_ptw_grp_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] vsid = '0;
  logic [15:0] pidx = '0;
  logic        sec = 1'b0;
  logic [31:0] tbl_base = '0;
  logic [8:0]  tbl_mask = '0;
  logic        busy, ent_rd, done, hit;
  logic [31:0] ent_addr;
  logic [63:0] ent_data;
  logic [2:0]  hit_idx;
  logic [19:0] hit_ppn;

  int total = 0;
  int bad = 0;
  logic [63:0] tbl [8];
  logic [31:0] cur_grp = 32'hFFFF_FFC0;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  ptw_grp_walker i_ptw_grp_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .vsid(vsid), .pidx(pidx),
    .sec(sec), .tbl_base(tbl_base), .tbl_mask(tbl_mask), .busy(busy),
    .ent_rd(ent_rd), .ent_addr(ent_addr), .ent_data(ent_data), .done(done),
    .hit(hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn)
  );

  always_comb begin
    if (ent_addr[31:6] == cur_grp[31:6]) ent_data = tbl[ent_addr[5:3]];
    else ent_data = 64'h0;
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  function automatic logic [31:0] exp_grp(input logic [23:0] v, input logic [15:0] p,
                                          input logic s, input logic [31:0] b,
                                          input logic [8:0] m);
    longint h, mid, g;
    h = longint'(v % 24'd524288) ^ longint'(p);
    if (s) h = 524287 - h;
    mid = ((b / 65536) % 512) | ((h / 1024) & m);
    g = (b / 33554432) * 33554432 + mid * 65536 + (h % 1024) * 64;
    return g[31:0];
  endfunction

  function automatic logic [63:0] mk(input logic vld, input logic [23:0] v,
                                     input logic h, input logic [5:0] a,
                                     input logic [19:0] ppn);
    return {vld, v, h, a, ppn, 12'hABC};
  endfunction

  task automatic search(input logic [23:0] v, input logic [15:0] p, input logic s,
                        input logic [31:0] b, input logic [8:0] m,
                        input int pos, input logic poke);
    logic [19:0] good_ppn;
    int last;
    good_ppn = 20'(pos * 4099) ^ rng[19:0];
    cur_grp = exp_grp(v, p, s, b, m);
    for (int i = 0; i < 8; i++) begin
      if (i < pos) begin
        case (i % 4)
          0: tbl[i] = mk(1'b0, v, s, p[15:10], 20'(i));
          1: tbl[i] = mk(1'b1, v ^ ((i % 8 == 1) ? 24'h800000 : 24'h000001), s, p[15:10], 20'(i));
          2: tbl[i] = mk(1'b1, v, ~s, p[15:10], 20'(i));
          default: tbl[i] = mk(1'b1, v, s, p[15:10] ^ 6'h20, 20'(i));
        endcase
      end else if (i == pos) tbl[i] = mk(1'b1, v, s, p[15:10], good_ppn);
      else tbl[i] = mk(1'b1, v, s, p[15:10], ~good_ppn);
    end
    @(negedge clk);
    vsid = v; pidx = p; sec = s; tbl_base = b; tbl_mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    vsid = ~v; pidx = ~p; sec = ~s; tbl_base = ~b;
    last = (pos < 8) ? pos : 7;
    for (int i = 0; i <= last; i++) begin
      start = 1'b0;
      if (s) chk(ent_rd && busy && !done && ent_addr == cur_grp + 32'(8 * i),
                 "R3 R5 secondary addr", longint'(ent_addr), longint'(cur_grp + 32'(8 * i)));
      else chk(ent_rd && busy && !done && ent_addr == cur_grp + 32'(8 * i),
               "R2 R4 R5 primary addr", longint'(ent_addr), longint'(cur_grp + 32'(8 * i)));
      if (poke && i == 1) start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done && !ent_rd && !busy, "R8 done after last read",
        longint'({done, ent_rd, busy}), 64'h4);
    if (pos < 8) begin
      chk(hit && hit_idx == 3'(pos) && hit_ppn == good_ppn, "R6 first match result",
          longint'({hit, hit_idx, hit_ppn}), longint'({1'b1, 3'(pos), good_ppn}));
    end else begin
      chk(!hit && hit_idx == 3'd0 && hit_ppn == 20'd0, "R7 miss result",
          longint'({hit, hit_idx, hit_ppn}), 64'h0);
    end
    if (poke) chk(hit_ppn == ((pos < 8) ? good_ppn : 20'd0), "R9 start ignored while busy",
                  longint'(hit_ppn), longint'((pos < 8) ? good_ppn : 20'd0));
    @(negedge clk);
    chk(!done && !ent_rd, "R8 done single cycle", longint'(done), 64'h0);
    chk(hit == (pos < 8) && hit_ppn == ((pos < 8) ? good_ppn : 20'd0), "R10 results held",
        longint'(hit_ppn), longint'((pos < 8) ? good_ppn : 20'd0));
    rng = nxt(rng);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [8:0] masks [4];
    masks[0] = 9'h000; masks[1] = 9'h1FF; masks[2] = 9'h0A5; masks[3] = 9'h13C;
    for (int i = 0; i < 8; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !hit && !ent_rd && hit_idx == 0 && hit_ppn == 0, "R1 reset state",
        longint'({busy, done, hit, ent_rd}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !ent_rd, "R1 idle after reset", longint'({busy, done, ent_rd}), 64'h0);
    for (int seed = 0; seed < 4; seed++) begin
      for (int s = 0; s < 2; s++) begin
        for (int pos = 0; pos <= 8; pos++) begin
          logic [31:0] b;
          rng = nxt(rng);
          b = {rng[31:16] & ~{7'h00, masks[seed]}, 16'h0000};
          search(rng[23:0] ^ 24'(seed * 977), rng[31:16] ^ 16'(pos * 301), s[0], b,
                 masks[seed], pos, (pos >= 2) && (pos % 3 == 0));
        end
      end
    end
    search(24'hFFFFFF, 16'hFFFF, 1'b0, 32'hFE00_0000, 9'h1FF, 3, 1'b1);
    search(24'h000000, 16'h0000, 1'b1, 32'h0000_0000, 9'h1FF, 8, 1'b1);
    search(24'h07FFFF, 16'h0000, 1'b0, 32'h1200_0000, 9'h000, 0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule